// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block decodes the host write cycles sent to a 16-bit NOR-style flash and decides what a read returns. Each write carries a command byte in the low eight data bits and an address. Single-cycle commands change the read mode: array data, the status register, identifier codes or query data. Two-cycle commands arm a sequence that the next write completes. The next write either starts a program or erase in a small engine model, or sets the sequence-error bits.

The block keeps an 8-bit status register. Bit 7 reports whether the engine is ready. Bits 4 and 5 hold sticky program and erase error flags. Bits 2 and 6 report a suspended program or a suspended erase. The array and the identifier and query contents are constant functions of the read address. The engine takes a fixed number of cycles. It reports a program failure when the data word is 0000h, and an erase failure when the erase address is 0.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode and the status register reads 80h, with bits 6 to 0 clear.
- R2: A write of 10h, 40h or C0h arms a program. The next write starts the engine with its address and data, whatever its value, and moves the block to status-read mode. SR7 then reads 0 for ENG_CYCLES clock edges and 1 afterwards.
- R3: After 20h, a write of D0h starts an erase at that write's address. Any other code sets SR4 and SR5, selects status-read mode and starts nothing, and the code after it is decoded as a fresh command.
- R4: After 60h, a write of D0h, 01h or 2Fh returns the block to array-read mode. Any other code sets SR4 and SR5 and selects status-read mode.
- R5: In status-read mode every read returns {8'h00, status}, whatever the read address.
- R6: A failed program (data 0000h) sets SR4 and a failed erase (address 0) sets SR5. The engine never clears either bit. Only 50h, written while the engine is idle, clears both, and it leaves the read mode unchanged.
- R7: B0h written while the engine runs freezes it and sets SR7 together with SR2 (program) or SR6 (erase). D0h then resumes it for its remaining cycles, clears the suspend bit and selects status-read mode.
- R8: While the engine is running and not suspended, every code other than 70h and B0h is ignored and arms no sequence.
- R9: 90h selects identifier mode: 00A7h at address 0, 44C1h at address 1, 0 elsewhere. 98h selects query mode: 0051h, 0052h and 0059h at addresses 10h to 12h, 0 elsewhere. FFh selects array mode, where a read returns the zero-extended address XOR 5A3Ch. These three codes are also accepted while the engine is suspended.
- R10: Reset aborts a running or suspended operation at once. The block is then idle with the R1 state.
- R11: In idle, a code that no command uses changes neither the read mode nor the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one write per asserted cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data; bits 7:0 hold the command code |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Read data for the current read mode |

## Verification
A write is taken at a rising edge and the new read mode is visible through the combinational read path right after that edge. The bench therefore drives each write for one cycle from a falling edge and compares rd_data at the next falling edge. Engine completion is due ENG_CYCLES edges after the starting write, or fewer after a resume. The bench polls SR7 once per falling edge and compares the number of edges it counted with the figure that follows from the cycle of the start, suspend and resume writes.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_IDENT  = 2'd2,
        MODE_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        SEQ_NONE  = 2'd0,
        SEQ_PROG  = 2'd1,
        SEQ_ERASE = 2'd2,
        SEQ_LOCK  = 2'd3
    } seq_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [15:0] addr;
        logic [15:0] data;
    } eng_req_t;

    localparam logic [7:0] C_PROG_ALT  = 8'h10;
    localparam logic [7:0] C_ERASE_SU  = 8'h20;
    localparam logic [7:0] C_PROG      = 8'h40;
    localparam logic [7:0] C_CLR_STAT  = 8'h50;
    localparam logic [7:0] C_LOCK_SU   = 8'h60;
    localparam logic [7:0] C_RD_STAT   = 8'h70;
    localparam logic [7:0] C_RD_IDENT  = 8'h90;
    localparam logic [7:0] C_RD_QUERY  = 8'h98;
    localparam logic [7:0] C_SUSPEND   = 8'hB0;
    localparam logic [7:0] C_PROT_PROG = 8'hC0;
    localparam logic [7:0] C_CONFIRM   = 8'hD0;
    localparam logic [7:0] C_LOCK      = 8'h01;
    localparam logic [7:0] C_LOCK_DOWN = 8'h2F;
    localparam logic [7:0] C_RD_ARRAY  = 8'hFF;

    localparam logic [15:0] ARRAY_MASK = 16'h5A3C;

    function automatic logic [15:0] array_word(input logic [15:0] a);
        return a ^ ARRAY_MASK;
    endfunction

    function automatic logic [15:0] ident_word(input logic [15:0] a);
        case (a)
            16'h0000: return 16'h00A7;
            16'h0001: return 16'h44C1;
            default:  return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] query_word(input logic [15:0] a);
        case (a)
            16'h0010: return 16'h0051;
            16'h0011: return 16'h0052;
            16'h0012: return 16'h0059;
            default:  return 16'h0000;
        endcase
    endfunction

    function automatic logic is_prog_setup(input logic [7:0] c);
        return (c == C_PROG) || (c == C_PROG_ALT) || (c == C_PROT_PROG);
    endfunction

    function automatic logic is_lock_second(input logic [7:0] c);
        return (c == C_CONFIRM) || (c == C_LOCK) || (c == C_LOCK_DOWN);
    endfunction

endpackage

// File: rtl/fcmd_engine.sv
module fcmd_engine
    import fcmd_pkg::*;
#(
    parameter int ENG_CYCLES = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  eng_req_t req,
    input  logic     suspend,
    input  logic     resume,
    output logic     busy,
    output logic     susp,
    output op_e      cur_op,
    output logic     fail_prog,
    output logic     fail_erase
);
    localparam int CNT_W = $clog2(ENG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ENG_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    eng_req_t         req_q;
    logic             busy_q;
    logic             susp_q;
    logic             tick;
    logic             finish;

    assign tick   = busy_q && !susp_q && !suspend;
    assign finish = tick && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            susp_q <= 1'b0;
            cnt_q  <= '0;
            req_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            susp_q <= 1'b0;
            cnt_q  <= CNT_LOAD;
            req_q  <= req;
        end else if (busy_q) begin
            if (suspend && !susp_q) begin
                susp_q <= 1'b1;
            end else if (resume && susp_q) begin
                susp_q <= 1'b0;
            end else if (finish) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else if (tick) begin
                cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    assign busy       = busy_q;
    assign susp       = susp_q;
    assign cur_op     = req_q.op;
    assign fail_prog  = finish && (req_q.op == OP_PROG)  && (req_q.data == 16'h0000);
    assign fail_erase = finish && (req_q.op == OP_ERASE) && (req_q.addr == 16'h0000);

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q) else $error("engine started while busy"); // R8

    AST_SUSPEND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (susp_q && !resume && !start) |=> $stable(cnt_q)) else $error("count moved while suspended"); // R7

endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
    import fcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_prog_err,
    input  logic       set_erase_err,
    input  logic       clear,
    input  logic       busy,
    input  logic       susp,
    input  op_e        cur_op,
    output logic [7:0] status
);
    logic prog_err_q;
    logic erase_err_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prog_err_q  <= 1'b0;
            erase_err_q <= 1'b0;
        end else begin
            prog_err_q  <= prog_err_q  | set_prog_err;
            erase_err_q <= erase_err_q | set_erase_err;
        end
    end

    assign status = {
        !busy || susp,
        susp && (cur_op == OP_ERASE),
        erase_err_q,
        prog_err_q,
        1'b0,
        susp && (cur_op == OP_PROG),
        2'b00
    };

    AST_PROG_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_err_q) |-> ($past(clear) || $past(rst))) else $error("SR4 fell without clear"); // R6

    AST_ERASE_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        $fell(erase_err_q) |-> ($past(clear) || $past(rst))) else $error("SR5 fell without clear"); // R6

    AST_ONE_SUSPEND_BIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({status[6], status[2]})) else $error("both suspend bits set"); // R7

endmodule

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import fcmd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              busy,
    input  logic              susp,
    output rd_mode_e          mode,
    output logic              eng_start,
    output eng_req_t          eng_req,
    output logic              eng_suspend,
    output logic              eng_resume,
    output logic              seq_err,
    output logic              sr_clear
);
    logic [7:0] cmd;
    seq_e       seq_q, seq_d;
    rd_mode_e   mode_q, mode_d;

    assign cmd = wr_data[7:0];

    always_comb begin
        seq_d         = seq_q;
        mode_d        = mode_q;
        eng_start     = 1'b0;
        eng_req.op    = OP_PROG;
        eng_req.addr  = 16'(wr_addr);
        eng_req.data  = wr_data;
        eng_suspend   = 1'b0;
        eng_resume    = 1'b0;
        seq_err       = 1'b0;
        sr_clear      = 1'b0;
        if (wr_en) begin
            if (seq_q != SEQ_NONE) begin
                seq_d = SEQ_NONE;
                case (seq_q)
                    SEQ_PROG: begin
                        eng_start = 1'b1;
                        mode_d    = MODE_STATUS;
                    end
                    SEQ_ERASE: begin
                        mode_d = MODE_STATUS;
                        if (cmd == C_CONFIRM) begin
                            eng_start  = 1'b1;
                            eng_req.op = OP_ERASE;
                        end else begin
                            seq_err = 1'b1;
                        end
                    end
                    default: begin
                        if (is_lock_second(cmd)) begin
                            mode_d = MODE_ARRAY;
                        end else begin
                            seq_err = 1'b1;
                            mode_d  = MODE_STATUS;
                        end
                    end
                endcase
            end else if (busy) begin
                if (cmd == C_RD_STAT) begin
                    mode_d = MODE_STATUS;
                end else if (cmd == C_SUSPEND && !susp) begin
                    eng_suspend = 1'b1;
                    mode_d      = MODE_STATUS;
                end else if (susp) begin
                    case (cmd)
                        C_CONFIRM: begin
                            eng_resume = 1'b1;
                            mode_d     = MODE_STATUS;
                        end
                        C_RD_IDENT: mode_d = MODE_IDENT;
                        C_RD_QUERY: mode_d = MODE_QUERY;
                        C_RD_ARRAY: mode_d = MODE_ARRAY;
                        default:    ;
                    endcase
                end
            end else begin
                if (is_prog_setup(cmd)) begin
                    seq_d = SEQ_PROG;
                end else begin
                    case (cmd)
                        C_ERASE_SU: seq_d    = SEQ_ERASE;
                        C_LOCK_SU:  seq_d    = SEQ_LOCK;
                        C_CLR_STAT: sr_clear = 1'b1;
                        C_RD_STAT:  mode_d   = MODE_STATUS;
                        C_RD_IDENT: mode_d   = MODE_IDENT;
                        C_RD_QUERY: mode_d   = MODE_QUERY;
                        C_RD_ARRAY: mode_d   = MODE_ARRAY;
                        default:    ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q  <= SEQ_NONE;
            mode_q <= MODE_ARRAY;
        end else begin
            seq_q  <= seq_d;
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    AST_AUTO_STATUS: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> (mode_q == MODE_STATUS)) else $error("no status mode after start"); // R2

    AST_SEQ_ERR_STATUS: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> (mode_q == MODE_STATUS && seq_q == SEQ_NONE)) else $error("sequence error left block armed"); // R3

    AST_NO_ARM_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && seq_q == SEQ_NONE) |=> (seq_q == SEQ_NONE)) else $error("sequence armed while busy"); // R8

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int ENG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data
);
    rd_mode_e   mode;
    eng_req_t   eng_req;
    op_e        cur_op;
    logic       eng_start, eng_suspend, eng_resume;
    logic       seq_err, sr_clear;
    logic       busy, susp, fail_prog, fail_erase;
    logic [7:0] status;
    logic [15:0] rd_a;

    fcmd_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .susp        (susp),
        .mode        (mode),
        .eng_start   (eng_start),
        .eng_req     (eng_req),
        .eng_suspend (eng_suspend),
        .eng_resume  (eng_resume),
        .seq_err     (seq_err),
        .sr_clear    (sr_clear)
    );

    fcmd_engine #(.ENG_CYCLES(ENG_CYCLES)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (eng_start),
        .req        (eng_req),
        .suspend    (eng_suspend),
        .resume     (eng_resume),
        .busy       (busy),
        .susp       (susp),
        .cur_op     (cur_op),
        .fail_prog  (fail_prog),
        .fail_erase (fail_erase)
    );

    fcmd_status u_status (
        .clk           (clk),
        .rst           (rst),
        .set_prog_err  (fail_prog  || seq_err),
        .set_erase_err (fail_erase || seq_err),
        .clear         (sr_clear),
        .busy          (busy),
        .susp          (susp),
        .cur_op        (cur_op),
        .status        (status)
    );

    assign rd_a = 16'(rd_addr);

    always_comb begin
        case (mode)
            MODE_STATUS: rd_data = {8'h00, status};
            MODE_IDENT:  rd_data = ident_word(rd_a);
            MODE_QUERY:  rd_data = query_word(rd_a);
            default:     rd_data = array_word(rd_a);
        endcase
    end

    AST_READY_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (status == 8'h80 && mode == MODE_ARRAY)) else $error("reset state wrong"); // R10

endmodule

// File: tb/fcmd_ctrl_bench.sv
module fcmd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int ENG_CYCLES = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [15:0]       rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    fcmd_ctrl #(.ADDR_W(ADDR_W), .ENG_CYCLES(ENG_CYCLES)) u_fcmd_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [7:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       exp;
    } vec_t;

    // Single-cycle commands in idle, each followed by one read (R5, R9, R11)
    localparam vec_t VECS [12] = '{
        '{8'hFF, 12'h012, 16'h5A2E},   // R9 array
        '{8'h90, 12'h000, 16'h00A7},   // R9 identifier
        '{8'h90, 12'h001, 16'h44C1},   // R9
        '{8'h90, 12'h005, 16'h0000},   // R9
        '{8'h98, 12'h010, 16'h0051},   // R9 query
        '{8'h98, 12'h012, 16'h0059},   // R9
        '{8'h98, 12'h013, 16'h0000},   // R9
        '{8'h70, 12'h7FF, 16'h0080},   // R5 status at any address
        '{8'h70, 12'h000, 16'h0080},   // R5
        '{8'h33, 12'h7FF, 16'h0080},   // R11 unknown code, still status
        '{8'hFF, 12'hFFF, 16'h55C3},   // R9
        '{8'h12, 12'h0AB, 16'h5A97}    // R11 unknown code, still array
    };

    task automatic do_write(input logic [15:0] d, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        wr_addr = a;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic check_rd(input string req, input logic [ADDR_W-1:0] a,
                            input logic [15:0] exp);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: addr %h read %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts falling edges until SR7 reads 1 (block must be in status mode)
    task automatic wait_ready(output int n);
        n = 0;
        rd_addr = '0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            #1;
            if (rd_data[7]) break;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog: run did not finish");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_rd("R1 array mode", 12'h012, 16'h5A2E);
        do_write(16'h0070, '0);
        check_rd("R1 status 80h", 12'h123, 16'h0080);

        // Vector table
        foreach (VECS[i]) begin
            do_write({8'h00, VECS[i].cmd}, '0);
            check_rd("R9/R5/R11 vector", VECS[i].addr, VECS[i].exp);
        end

        // R2: program, automatic status mode, busy for ENG_CYCLES
        do_write(16'h0040, 12'h003);
        do_write(16'h1234, 12'h003);
        check_rd("R2 busy status", 12'h3FF, 16'h0000);
        wait_ready(n);
        check_int("R2 program duration", n, ENG_CYCLES);
        check_rd("R2 done status", 12'h000, 16'h0080);

        // R8: codes ignored while running
        do_write(16'h0010, 12'h004);
        do_write(16'h00FF, 12'h004);
        do_write(16'h0090, '0);
        check_rd("R8 90h ignored while busy", 12'h000, 16'h0000);
        do_write(16'h0040, '0);
        wait_ready(n);
        do_write(16'h0098, '0);
        check_rd("R8 40h did not arm program", 12'h010, 16'h0051);

        // R6: program failure via C0h, sticky, clear
        do_write(16'h00C0, 12'h002);
        do_write(16'h0000, 12'h002);
        wait_ready(n);
        check_rd("R6 program fail SR4", 12'h000, 16'h0090);
        do_write(16'h0050, '0);
        check_rd("R6 clear keeps status mode", 12'h000, 16'h0080);

        // R6: erase failure at address 0, engine cannot clear, 50h ignored when busy
        do_write(16'h0020, 12'h000);
        do_write(16'h00D0, 12'h000);
        wait_ready(n);
        check_int("R3 erase duration", n, ENG_CYCLES);
        check_rd("R6 erase fail SR5", 12'h000, 16'h00A0);
        do_write(16'h0040, 12'h001);
        do_write(16'h0001, 12'h001);
        do_write(16'h0050, '0);
        wait_ready(n);
        check_rd("R6 sticky across good program and busy clear", 12'h000, 16'h00A0);
        do_write(16'h0050, '0);
        check_rd("R6 idle clear", 12'h000, 16'h0080);

        // R3: erase sequence error
        do_write(16'h0020, 12'h005);
        do_write(16'h0040, 12'h005);
        check_rd("R3 sequence error bits, ready", 12'h7AB, 16'h00B0);
        do_write(16'h0098, '0);
        check_rd("R3 next code decoded fresh", 12'h011, 16'h0052);
        do_write(16'h0050, '0);
        do_write(16'h0070, '0);
        check_rd("R3 cleared", 12'h000, 16'h0080);

        // R4: lock sequences
        do_write(16'h0060, 12'h008);
        do_write(16'h0001, 12'h008);
        check_rd("R4 lock 01h to array", 12'h012, 16'h5A2E);
        do_write(16'h0060, 12'h008);
        do_write(16'h002F, 12'h008);
        check_rd("R4 lock-down 2Fh to array", 12'h0AB, 16'h5A97);
        do_write(16'h0060, 12'h008);
        do_write(16'h00D0, 12'h008);
        check_rd("R4 unlock D0h to array", 12'h012, 16'h5A2E);
        do_write(16'h0060, 12'h008);
        do_write(16'h0055, 12'h008);
        check_rd("R4 bad second code", 12'h012, 16'h00B0);
        do_write(16'h0050, '0);

        // R7: program suspend and resume
        do_write(16'h0040, 12'h006);
        do_write(16'h4321, 12'h006);
        do_write(16'h00B0, '0);
        check_rd("R7 program suspend SR2+SR7", 12'h000, 16'h0084);
        repeat (20) @(negedge clk);
        check_rd("R7 stays suspended", 12'h000, 16'h0084);
        do_write(16'h0090, '0);
        check_rd("R9 identifier while suspended", 12'h001, 16'h44C1);
        do_write(16'h00D0, '0);
        check_rd("R7 resumed busy", 12'h000, 16'h0000);
        wait_ready(n);
        check_int("R7 remaining cycles after resume", n, ENG_CYCLES - 1);

        // R7: erase suspend
        do_write(16'h0020, 12'h004);
        do_write(16'h00D0, 12'h004);
        do_write(16'h00B0, '0);
        check_rd("R7 erase suspend SR6+SR7", 12'h000, 16'h00C0);
        do_write(16'h00D0, '0);
        wait_ready(n);
        check_rd("R7 erase completes clean", 12'h000, 16'h0080);

        // R10: reset aborts a running operation
        do_write(16'h0040, 12'h002);
        do_write(16'h0000, 12'h002);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_rd("R10 array after abort", 12'h012, 16'h5A2E);
        do_write(16'h0070, '0);
        check_rd("R10 idle, no failure bit", 12'h000, 16'h0080);
        repeat (ENG_CYCLES + 2) @(negedge clk);
        check_rd("R10 aborted op never reports", 12'h000, 16'h0080);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule